// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block keeps the fetch state of every hardware thread in a multithreaded front end and advances it once per clock from the control traffic that the later pipeline stages send back. For each thread it holds a status code, a three-deep program-counter set (current, next and the one after that), and four sticky stall flags, one for each downstream stage (decode, rename, execute, commit). A downstream stage sets its flag with a block pulse and clears it with an unblock pulse. Redirects arrive either from commit or from decode, each carrying a new PC and next PC.

Each cycle a fixed priority chain picks at most one control rule per active thread: commit redirect, commit squash-in-progress, decode redirect, stall, then recovery to Running. When none of these rules fires, the fetch engine may write a new status (for instance, to enter or leave an instruction-cache wait). All outputs are registered and change on the clock edge that samples the inputs. A stage-level activity flag tells the core whether any active thread can make fetch progress.

Top module: `fetch_status_ctl`

## Requirements
- R1: After synchronous reset, every thread's status is Running (code 0), all PCs are zero, all stall flags are clear, and both the changed flags and the error flags are 0.
- R2: A commit redirect on an active thread loads PC with the redirect PC, next PC with the redirect next PC, and next-next PC with the redirect next PC plus INST_BYTES, and sets the status to Squashing (code 2), all on the sampling edge.
- R3: When commit and decode both redirect the same thread in one cycle, the commit values are taken.
- R4: When there is no commit redirect, a commit squash-in-progress flag sets the status to Squashing and leaves the PCs unchanged.
- R5: A decode redirect is applied only if the thread's status is not Squashing. Otherwise, its PC values are discarded.
- R6: A block pulse sets that stage's stall flag, and the flag stays set until its unblock pulse arrives. A thread is stalled when any of its flags (after this cycle's pulses) is set or the global context-switch input is high. A stalled thread becomes Blocked (code 3).
- R7: A stall does not change a thread in IcacheWaitResponse (code 6) or IcacheWaitRetry (code 7).
- R8: A Blocked or Squashing thread returns to Running in the first cycle in which no higher-priority rule fires.
- R9: An unblock pulse that finds its flag already clear, or that arrives together with a block pulse for the same stage, raises that thread's error flag on the next edge. A simultaneous block and unblock leaves the flag clear.
- R10: A fetch-engine status write (legal codes 0 to 8) takes effect only when no control rule fires for that thread in that cycle. Codes above 8 are ignored.
- R11: A thread whose active bit is low keeps its status, PCs and stall flags unchanged, and its changed flag reads 0.
- R12: The stage-active output is 1 when some active thread's updated status is Running, Squashing or IcacheAccessComplete (code 8), and 0 otherwise.
- R13: A thread's changed flag is 1 for the cycle after any control rule or fetch write has updated its status or PCs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thread_active | input | NT | Per-thread enable for all updates |
| ctx_switch | input | 1 | Global context switch, which stalls every thread |
| dec_block | input | NT | Decode block pulse per thread |
| dec_unblock | input | NT | Decode unblock pulse per thread |
| ren_block | input | NT | Rename block pulse per thread |
| ren_unblock | input | NT | Rename unblock pulse per thread |
| exe_block | input | NT | Execute block pulse per thread |
| exe_unblock | input | NT | Execute unblock pulse per thread |
| cmt_block | input | NT | Commit block pulse per thread |
| cmt_unblock | input | NT | Commit unblock pulse per thread |
| cmt_squash | input | NT | Commit redirect request per thread |
| cmt_redir_pc | input | NT*AW | Commit redirect PC, thread t at bits t*AW |
| cmt_redir_npc | input | NT*AW | Commit redirect next PC |
| cmt_squash_busy | input | NT | Commit still squashing per thread |
| dec_squash | input | NT | Decode redirect request per thread |
| dec_redir_pc | input | NT*AW | Decode redirect PC |
| dec_redir_npc | input | NT*AW | Decode redirect next PC |
| fetch_wr | input | NT | Fetch-engine status write strobe |
| fetch_status | input | NT*4 | Fetch-engine status code, thread t at bits t*4 |
| thread_status | output | NT*4 | Registered status code per thread |
| pc | output | NT*AW | Current PC per thread |
| npc | output | NT*AW | Next PC per thread |
| nnpc | output | NT*AW | Next-next PC per thread |
| status_changed | output | NT | Per-thread update flag |
| unblock_err | output | NT | Per-thread unblock protocol error |
| stage_active | output | 1 | Any active thread can make fetch progress |

## Verification
The main collision cases are these. A stall and a fetch-engine status write can land on the same thread in the same cycle. A commit redirect and a decode redirect can also land on the same thread together. Directed tasks raise a block pulse together with a fetch write of IcacheWaitResponse, and raise both redirect requests with different PC values. The checks then require that the stall rule wins over the write, and that the commit PC wins over the decode PC. A block pulse against a thread already waiting on the cache, and a block and unblock pulse on the same stage, probe the same kind of overlap from the stall side.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  localparam int STATUS_W = 4;
  localparam int NSTAGE   = 4;

  // stall flag positions inside each thread's flag vector
  localparam int STG_DEC = 0;
  localparam int STG_REN = 1;
  localparam int STG_EXE = 2;
  localparam int STG_CMT = 3;

  typedef enum logic [STATUS_W-1:0] {
    ST_RUNNING    = 4'd0,
    ST_IDLE       = 4'd1,
    ST_SQUASHING  = 4'd2,
    ST_BLOCKED    = 4'd3,
    ST_TRAP_WAIT  = 4'd4,
    ST_QUIES_WAIT = 4'd5,
    ST_IC_RESP    = 4'd6,
    ST_IC_RETRY   = 4'd7,
    ST_IC_DONE    = 4'd8
  } fstat_e;

  localparam logic [STATUS_W-1:0] ST_MAX_CODE = 4'd8;

  function automatic logic can_progress(input fstat_e s);
    return (s == ST_RUNNING) || (s == ST_SQUASHING) || (s == ST_IC_DONE);
  endfunction

  function automatic logic waits_on_icache(input fstat_e s);
    return (s == ST_IC_RESP) || (s == ST_IC_RETRY);
  endfunction

endpackage

// File: rtl/fsc_stall_track.sv
module fsc_stall_track
  import fsc_pkg::*;
#(
  parameter int STAGES = NSTAGE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [STAGES-1:0] blk,
  input  logic [STAGES-1:0] unblk,
  output logic [STAGES-1:0] flags_nxt,
  output logic              err_q
);

  logic [STAGES-1:0] flags_q;
  logic [STAGES-1:0] bad_unblk;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_flag
      always_comb begin
        flags_nxt[g] = flags_q[g];
        if (en) begin
          if (blk[g])   flags_nxt[g] = 1'b1;
          if (unblk[g]) flags_nxt[g] = 1'b0;
        end
      end
      assign bad_unblk[g] = en & unblk[g] & (~flags_q[g] | blk[g]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      err_q   <= 1'b0;
    end else begin
      flags_q <= flags_nxt;
      err_q   <= |bad_unblk;
    end
  end

  // R6: a lone block pulse leaves the flag set
  a_r6_block_sets: assert property (@(posedge clk) disable iff (rst)
    en |=> ((flags_q & $past(blk & ~unblk)) == $past(blk & ~unblk)));

  // R9: an unblock on a clear flag is reported
  a_r9_unblock_err: assert property (@(posedge clk) disable iff (rst)
    (en && |(unblk & ~flags_q)) |=> err_q);

  // R11: disabled thread keeps its flags
  a_r11_flags_frozen: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(flags_q));

endmodule

// File: rtl/fsc_thread_ctl.sv
module fsc_thread_ctl
  import fsc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int INST_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                active,
  input  logic                stalled,
  input  logic                cmt_sq,
  input  logic [AW-1:0]       cmt_pc,
  input  logic [AW-1:0]       cmt_npc,
  input  logic                cmt_busy,
  input  logic                dec_sq,
  input  logic [AW-1:0]       dec_pc,
  input  logic [AW-1:0]       dec_npc,
  input  logic                fetch_wr,
  input  logic [STATUS_W-1:0] fetch_st,
  output fstat_e              st_q,
  output fstat_e              st_nxt,
  output logic [AW-1:0]       pc_q,
  output logic [AW-1:0]       npc_q,
  output logic [AW-1:0]       nnpc_q,
  output logic                chg_q
);

  localparam logic [AW-1:0] STEP = AW'(INST_BYTES);

  logic [AW-1:0] pc_n, npc_n, nnpc_n;
  logic          fire;

  always_comb begin
    st_nxt = st_q;
    pc_n   = pc_q;
    npc_n  = npc_q;
    nnpc_n = nnpc_q;
    fire   = 1'b0;
    if (active) begin
      if (cmt_sq) begin
        pc_n   = cmt_pc;
        npc_n  = cmt_npc;
        nnpc_n = cmt_npc + STEP;
        st_nxt = ST_SQUASHING;
        fire   = 1'b1;
      end else if (cmt_busy) begin
        st_nxt = ST_SQUASHING;
        fire   = 1'b1;
      end else if (dec_sq && st_q != ST_SQUASHING) begin
        pc_n   = dec_pc;
        npc_n  = dec_npc;
        nnpc_n = dec_npc + STEP;
        st_nxt = ST_SQUASHING;
        fire   = 1'b1;
      end else if (stalled && !waits_on_icache(st_q)) begin
        st_nxt = ST_BLOCKED;
        fire   = 1'b1;
      end else if (st_q == ST_BLOCKED || st_q == ST_SQUASHING) begin
        st_nxt = ST_RUNNING;
        fire   = 1'b1;
      end else if (fetch_wr && fetch_st <= ST_MAX_CODE) begin
        st_nxt = fstat_e'(fetch_st);
        fire   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_RUNNING;
      pc_q   <= '0;
      npc_q  <= '0;
      nnpc_q <= '0;
      chg_q  <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      pc_q   <= pc_n;
      npc_q  <= npc_n;
      nnpc_q <= nnpc_n;
      chg_q  <= fire;
    end
  end

  // R2: commit redirect loads the PC set and enters Squashing
  a_r2_commit_redirect: assert property (@(posedge clk) disable iff (rst)
    (active && cmt_sq) |=> (st_q == ST_SQUASHING && pc_q == $past(cmt_pc)
                            && nnpc_q == $past(cmt_npc) + STEP));

  // R4: squash-in-progress keeps PCs
  a_r4_busy_holds_pc: assert property (@(posedge clk) disable iff (rst)
    (active && !cmt_sq && cmt_busy) |=> (st_q == ST_SQUASHING && $stable(pc_q)));

  // R7: cache wait survives a stall
  a_r7_icache_wait_kept: assert property (@(posedge clk) disable iff (rst)
    (active && !cmt_sq && !cmt_busy && !dec_sq && !fetch_wr && st_q == ST_IC_RESP)
      |=> st_q == ST_IC_RESP);

  // R10: status code stays within the legal set
  a_r10_legal_code: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> st_q <= ST_MAX_CODE);

  // R11: an inactive thread is frozen
  a_r11_inactive_frozen: assert property (@(posedge clk) disable iff (rst)
    !active |=> ($stable(st_q) && $stable(pc_q) && !chg_q));

endmodule

// File: rtl/fsc_activity.sv
module fsc_activity
  import fsc_pkg::*;
#(
  parameter int NT = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NT-1:0]          active,
  input  logic [NT*STATUS_W-1:0] st_nxt_flat,
  output logic                   stage_active_q
);

  logic [NT-1:0] prog;

  genvar g;
  generate
    for (g = 0; g < NT; g++) begin : g_prog
      assign prog[g] = active[g] &
        can_progress(fstat_e'(st_nxt_flat[g*STATUS_W +: STATUS_W]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) stage_active_q <= 1'b0;
    else     stage_active_q <= |prog;
  end

  // R12: no active thread means an idle stage
  a_r12_none_active: assert property (@(posedge clk) disable iff (rst)
    (active == '0) |=> !stage_active_q);

endmodule

// File: rtl/fetch_status_ctl.sv
module fetch_status_ctl
  import fsc_pkg::*;
#(
  parameter int NT         = 4,
  parameter int AW         = 32,
  parameter int INST_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NT-1:0]          thread_active,
  input  logic                   ctx_switch,
  input  logic [NT-1:0]          dec_block,
  input  logic [NT-1:0]          dec_unblock,
  input  logic [NT-1:0]          ren_block,
  input  logic [NT-1:0]          ren_unblock,
  input  logic [NT-1:0]          exe_block,
  input  logic [NT-1:0]          exe_unblock,
  input  logic [NT-1:0]          cmt_block,
  input  logic [NT-1:0]          cmt_unblock,
  input  logic [NT-1:0]          cmt_squash,
  input  logic [NT*AW-1:0]       cmt_redir_pc,
  input  logic [NT*AW-1:0]       cmt_redir_npc,
  input  logic [NT-1:0]          cmt_squash_busy,
  input  logic [NT-1:0]          dec_squash,
  input  logic [NT*AW-1:0]       dec_redir_pc,
  input  logic [NT*AW-1:0]       dec_redir_npc,
  input  logic [NT-1:0]          fetch_wr,
  input  logic [NT*STATUS_W-1:0] fetch_status,
  output logic [NT*STATUS_W-1:0] thread_status,
  output logic [NT*AW-1:0]       pc,
  output logic [NT*AW-1:0]       npc,
  output logic [NT*AW-1:0]       nnpc,
  output logic [NT-1:0]          status_changed,
  output logic [NT-1:0]          unblock_err,
  output logic                   stage_active
);

  logic [NT*STATUS_W-1:0] st_nxt_flat;

  genvar t;
  generate
    for (t = 0; t < NT; t++) begin : g_thr
      logic [NSTAGE-1:0] blk, unblk, flags_nxt;
      logic              stalled;
      fstat_e            st_cur, st_nxt;

      always_comb begin
        blk          = '0;
        unblk        = '0;
        blk[STG_DEC]   = dec_block[t];
        blk[STG_REN]   = ren_block[t];
        blk[STG_EXE]   = exe_block[t];
        blk[STG_CMT]   = cmt_block[t];
        unblk[STG_DEC] = dec_unblock[t];
        unblk[STG_REN] = ren_unblock[t];
        unblk[STG_EXE] = exe_unblock[t];
        unblk[STG_CMT] = cmt_unblock[t];
      end

      fsc_stall_track #(.STAGES(NSTAGE)) u_stall (
        .clk       (clk),
        .rst       (rst),
        .en        (thread_active[t]),
        .blk       (blk),
        .unblk     (unblk),
        .flags_nxt (flags_nxt),
        .err_q     (unblock_err[t])
      );

      assign stalled = ctx_switch | (|flags_nxt);

      fsc_thread_ctl #(.AW(AW), .INST_BYTES(INST_BYTES)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .active   (thread_active[t]),
        .stalled  (stalled),
        .cmt_sq   (cmt_squash[t]),
        .cmt_pc   (cmt_redir_pc[t*AW +: AW]),
        .cmt_npc  (cmt_redir_npc[t*AW +: AW]),
        .cmt_busy (cmt_squash_busy[t]),
        .dec_sq   (dec_squash[t]),
        .dec_pc   (dec_redir_pc[t*AW +: AW]),
        .dec_npc  (dec_redir_npc[t*AW +: AW]),
        .fetch_wr (fetch_wr[t]),
        .fetch_st (fetch_status[t*STATUS_W +: STATUS_W]),
        .st_q     (st_cur),
        .st_nxt   (st_nxt),
        .pc_q     (pc[t*AW +: AW]),
        .npc_q    (npc[t*AW +: AW]),
        .nnpc_q   (nnpc[t*AW +: AW]),
        .chg_q    (status_changed[t])
      );

      assign thread_status[t*STATUS_W +: STATUS_W] = st_cur;
      assign st_nxt_flat[t*STATUS_W +: STATUS_W]   = st_nxt;

      // R6: a stalled thread outside a cache wait ends up Blocked
      a_r6_stall_blocks: assert property (@(posedge clk) disable iff (rst)
        (thread_active[t] && ctx_switch && !cmt_squash[t] && !cmt_squash_busy[t]
         && !dec_squash[t] && !waits_on_icache(st_cur))
          |=> thread_status[t*STATUS_W +: STATUS_W] == ST_BLOCKED);
    end
  endgenerate

  fsc_activity #(.NT(NT)) u_act (
    .clk            (clk),
    .rst            (rst),
    .active         (thread_active),
    .st_nxt_flat    (st_nxt_flat),
    .stage_active_q (stage_active)
  );

endmodule

// File: tb/fetch_status_ctl_bench.sv
`timescale 1ns/1ps
module fetch_status_ctl_bench;
  localparam int NT = 4;
  localparam int AW = 32;
  localparam int SW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst;
  logic [NT-1:0] thread_active;
  logic ctx_switch;
  logic [NT-1:0] dec_block, dec_unblock, ren_block, ren_unblock;
  logic [NT-1:0] exe_block, exe_unblock, cmt_block, cmt_unblock;
  logic [NT-1:0] cmt_squash, cmt_squash_busy, dec_squash, fetch_wr;
  logic [NT*AW-1:0] cmt_redir_pc, cmt_redir_npc, dec_redir_pc, dec_redir_npc;
  logic [NT*SW-1:0] fetch_status;
  logic [NT*SW-1:0] thread_status;
  logic [NT*AW-1:0] pc, npc, nnpc;
  logic [NT-1:0] status_changed, unblock_err;
  logic stage_active;

  int n_checks = 0;
  int n_fail = 0;

  fetch_status_ctl #(.NT(NT), .AW(AW), .INST_BYTES(4)) u_fetch_status_ctl (
    .clk(clk), .rst(rst), .thread_active(thread_active), .ctx_switch(ctx_switch),
    .dec_block(dec_block), .dec_unblock(dec_unblock),
    .ren_block(ren_block), .ren_unblock(ren_unblock),
    .exe_block(exe_block), .exe_unblock(exe_unblock),
    .cmt_block(cmt_block), .cmt_unblock(cmt_unblock),
    .cmt_squash(cmt_squash), .cmt_redir_pc(cmt_redir_pc), .cmt_redir_npc(cmt_redir_npc),
    .cmt_squash_busy(cmt_squash_busy),
    .dec_squash(dec_squash), .dec_redir_pc(dec_redir_pc), .dec_redir_npc(dec_redir_npc),
    .fetch_wr(fetch_wr), .fetch_status(fetch_status),
    .thread_status(thread_status), .pc(pc), .npc(npc), .nnpc(nnpc),
    .status_changed(status_changed), .unblock_err(unblock_err),
    .stage_active(stage_active)
  );

  function automatic logic [31:0] st_of(input int t);
    return 32'(thread_status[t*SW +: SW]);
  endfunction
  function automatic logic [31:0] pc_of(input int t);
    return pc[t*AW +: AW];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clr_pulses();
    dec_block = '0; dec_unblock = '0; ren_block = '0; ren_unblock = '0;
    exe_block = '0; exe_unblock = '0; cmt_block = '0; cmt_unblock = '0;
    cmt_squash = '0; cmt_squash_busy = '0; dec_squash = '0; fetch_wr = '0;
    cmt_redir_pc = '0; cmt_redir_npc = '0; dec_redir_pc = '0; dec_redir_npc = '0;
    fetch_status = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    clr_pulses();
  endtask

  task automatic t_reset();
    rst = 1'b1; thread_active = '1; ctx_switch = 1'b0; clr_pulses();
    tick(); tick();
    rst = 1'b0;
    for (int t = 0; t < NT; t++) begin
      chk("R1", "status", st_of(t), 0);
      chk("R1", "pc", pc_of(t), 0);
    end
    chk("R1", "changed", 32'(status_changed), 0);
    chk("R1", "err", 32'(unblock_err), 0);
    tick();
    chk("R12", "stage_active all running", 32'(stage_active), 1);
  endtask

  task automatic t_commit_redirect();
    cmt_squash[0] = 1'b1;
    cmt_redir_pc[0*AW +: AW] = 32'h1000; cmt_redir_npc[0*AW +: AW] = 32'h1004;
    tick();
    chk("R2", "st0", st_of(0), 2);
    chk("R2", "pc0", pc_of(0), 32'h1000);
    chk("R2", "npc0", npc[0 +: AW], 32'h1004);
    chk("R2", "nnpc0", nnpc[0 +: AW], 32'h1008);
    chk("R13", "changed", 32'(status_changed), 32'b0001);
    tick();
    chk("R8", "st0 back to running", st_of(0), 0);
    chk("R13", "changed on recovery", 32'(status_changed[0]), 1);
    tick();
    chk("R13", "changed idle", 32'(status_changed), 0);
  endtask

  task automatic t_priority_busy_decode();
    cmt_squash[1] = 1'b1; dec_squash[1] = 1'b1;
    cmt_redir_pc[1*AW +: AW] = 32'h2000; cmt_redir_npc[1*AW +: AW] = 32'h2004;
    dec_redir_pc[1*AW +: AW] = 32'h3000; dec_redir_npc[1*AW +: AW] = 32'h3004;
    tick();
    chk("R3", "pc1 commit wins", pc_of(1), 32'h2000);
    cmt_squash_busy[1] = 1'b1; dec_squash[1] = 1'b1;
    dec_redir_pc[1*AW +: AW] = 32'h3000;
    tick();
    chk("R4", "st1 busy", st_of(1), 2);
    chk("R4", "pc1 held", pc_of(1), 32'h2000);
    dec_squash[1] = 1'b1; dec_redir_pc[1*AW +: AW] = 32'h4000;
    tick();
    chk("R5", "pc1 decode ignored while squashing", pc_of(1), 32'h2000);
    chk("R8", "st1 running", st_of(1), 0);
    dec_squash[1] = 1'b1;
    dec_redir_pc[1*AW +: AW] = 32'h5000; dec_redir_npc[1*AW +: AW] = 32'h5010;
    tick();
    chk("R5", "pc1 decode applied", pc_of(1), 32'h5000);
    chk("R5", "nnpc1", nnpc[1*AW +: AW], 32'h5014);
    chk("R5", "st1", st_of(1), 2);
    tick();
  endtask

  task automatic t_sticky_stall();
    ren_block[2] = 1'b1;
    tick();
    chk("R6", "st2 blocked", st_of(2), 3);
    tick(); tick();
    chk("R6", "st2 still blocked", st_of(2), 3);
    ren_unblock[2] = 1'b1;
    tick();
    chk("R8", "st2 running after unblock", st_of(2), 0);
    chk("R9", "no error on legal unblock", 32'(unblock_err), 0);
  endtask

  task automatic t_ctx_switch();
    ctx_switch = 1'b1;
    tick();
    for (int t = 0; t < NT; t++) chk("R6", "ctx blocks", st_of(t), 3);
    chk("R12", "stage idle when all blocked", 32'(stage_active), 0);
    ctx_switch = 1'b0;
    tick();
    for (int t = 0; t < NT; t++) chk("R8", "ctx release", st_of(t), 0);
    chk("R12", "stage active again", 32'(stage_active), 1);
  endtask

  task automatic t_icache_wait();
    fetch_wr[3] = 1'b1; fetch_status[3*SW +: SW] = 4'd6;
    tick();
    chk("R10", "st3 wait resp", st_of(3), 6);
    exe_block[3] = 1'b1;
    tick();
    chk("R7", "st3 kept under stall", st_of(3), 6);
    chk("R7", "changed3", 32'(status_changed[3]), 0);
    fetch_wr[3] = 1'b1; fetch_status[3*SW +: SW] = 4'd8;
    tick();
    chk("R10", "st3 access complete", st_of(3), 8);
    tick();
    chk("R6", "st3 blocked by kept flag", st_of(3), 3);
    exe_unblock[3] = 1'b1;
    tick();
    chk("R8", "st3 running", st_of(3), 0);
    fetch_wr[3] = 1'b1; fetch_status[3*SW +: SW] = 4'd12;
    tick();
    chk("R10", "illegal code ignored", st_of(3), 0);
  endtask

  task automatic t_fetch_vs_stall();
    cmt_block[0] = 1'b1; fetch_wr[0] = 1'b1; fetch_status[0 +: SW] = 4'd6;
    tick();
    chk("R10", "stall beats fetch write", st_of(0), 3);
    cmt_unblock[0] = 1'b1;
    tick();
    chk("R8", "st0 running", st_of(0), 0);
  endtask

  task automatic t_protocol_err();
    dec_unblock[0] = 1'b1;
    tick();
    chk("R9", "err on clear flag", 32'(unblock_err), 32'b0001);
    tick();
    chk("R9", "err is a pulse", 32'(unblock_err), 0);
    dec_block[0] = 1'b1; dec_unblock[0] = 1'b1;
    tick();
    chk("R9", "err on block+unblock", 32'(unblock_err[0]), 1);
    chk("R9", "flag left clear", st_of(0), 0);
    tick();
    chk("R9", "still running", st_of(0), 0);
  endtask

  task automatic t_inactive();
    thread_active = 4'b1101;
    cmt_squash[1] = 1'b1; cmt_redir_pc[1*AW +: AW] = 32'h7000;
    ren_block[1] = 1'b1;
    tick();
    chk("R11", "pc1 frozen", pc_of(1), 32'h5000);
    chk("R11", "st1 frozen", st_of(1), 0);
    chk("R11", "changed1", 32'(status_changed[1]), 0);
    thread_active = 4'b1111;
    tick();
    chk("R11", "no flag stored while inactive", st_of(1), 0);
    thread_active = 4'b1000;
    fetch_wr[3] = 1'b1; fetch_status[3*SW +: SW] = 4'd6;
    tick();
    chk("R12", "only waiting thread active", 32'(stage_active), 0);
    thread_active = 4'b0000;
    tick();
    chk("R12", "no active thread", 32'(stage_active), 0);
  endtask

  initial begin
    t_reset();
    t_commit_redirect();
    t_priority_busy_decode();
    t_sticky_stall();
    t_ctx_switch();
    t_icache_wait();
    t_fetch_vs_stall();
    t_protocol_err();
    t_inactive();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule